// File: doc/BRIEF.md
# Set-Associative Tag Directory with Programmable Victim Selection

This block is the tag side of a highly associative cache with 32-byte lines. Each cycle it can take one lookup. The lookup carries a 32-bit address and a flag that marks the access as not cacheable. One cycle later the block reports whether the line is present and which way holds it. It also reports whether the miss should start a line fill or pass the memory straight through. The data array, the memory fill protocol, coherency and address translation sit outside the block.

Hardware ageing does not pick the way to replace. Each set has its own small register that names the way the next fill of that set will overwrite. After each fill into a set, that set's register moves on by one and wraps at the way count. Software can read and overwrite any set's register through a simple register port, which addresses the registers by set number. A separate invalidate-all input drops every line at once. It does not touch the victim registers.

Top module: `victim_tag_dir`

## Requirements
- R1: An address splits as follows: bits [4:0] are the byte offset and play no part in a lookup or a fill. The next log2(NUM_SETS) bits select the set. All remaining upper bits form the tag.
- R2: A lookup presented with `lk_valid` high is answered on the following cycle with `rsp_valid` high. In a cycle with no lookup, every `rsp_*` output is zero on the next cycle.
- R3: `rsp_hit` is 1 only when exactly one valid way of the selected set holds a matching tag. `rsp_way` then gives that way as an unsigned binary number.
- R4: When two or more valid ways of the set match, the lookup is reported as a miss.
- R5: A miss on a cacheable lookup raises `rsp_fill`. `rsp_victim` carries the set's victim register value as it stood when the lookup was sampled.
- R6: An inhibited lookup always raises `rsp_bypass` and never raises `rsp_fill`. Its hit result is still reported.
- R7: `fill_en` writes the tag of `fill_addr` into the way named by that set's victim register and marks the way valid. The register then becomes (value + 1) modulo NUM_WAYS.
- R8: A register write to a set replaces its victim value. When it coincides with a fill to the same set, the fill still uses the old value, and the written value is what remains.
- R9: `reg_rdata` returns the victim value of set `reg_addr`, zero-extended to 32 bits. Writes keep only the low log2(NUM_WAYS) bits of `reg_wdata`.
- R10: `inval_all` clears every valid bit and leaves all victim registers unchanged. A fill in the same cycle is discarded, and the victim register does not advance.
- R11: After reset, no way is valid, every victim register reads 0 and all `rsp_*` outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_addr | input | ADDR_W | Lookup address |
| lk_inhibit | input | 1 | Lookup is caching-inhibited |
| fill_en | input | 1 | Install a line this cycle |
| fill_addr | input | ADDR_W | Address of the line being installed |
| inval_all | input | 1 | Clear every valid bit |
| reg_we | input | 1 | Victim register write strobe |
| reg_addr | input | log2(NUM_SETS) | Set number for register read and write |
| reg_wdata | input | 32 | Victim register write data |
| reg_rdata | output | 32 | Victim register read data, zero-extended |
| rsp_valid | output | 1 | Response for last cycle's lookup |
| rsp_hit | output | 1 | Exactly one valid way matched |
| rsp_way | output | log2(NUM_WAYS) | Matching way, binary |
| rsp_fill | output | 1 | Cacheable miss, a fill is needed |
| rsp_bypass | output | 1 | Inhibited access, bypass the cache |
| rsp_victim | output | log2(NUM_WAYS) | Way a fill of that set would replace |

## Verification
The bench builds the block with 8 ways and 4 sets. With only 8 ways, the victim register wraps after a handful of fills, so wrap-around and the eviction of a still-live line are both easy to reach. With only 4 sets, random traffic from a small tag pool revisits the same set often enough to hit, miss, evict and create duplicate tags many times. Directed cases cover the corners that random traffic seldom produces: a fill and a register write to the same set in the same cycle, invalidate-all together with a fill, masked writes, and lookups that differ only in the offset bits.

// File: rtl/vtd_pkg.sv
// Shared constants for the victim-directed tag directory.
// Assumes 32-byte lines and a 32-bit register port.
package vtd_pkg;
    localparam int OFFSET_W = 5;   // byte offset bits of a 32-byte line
    localparam int REG_W    = 32;  // register port data width
endpackage

// File: rtl/vtd_tag_store.sv
// Tag and valid storage, organised as one column per way.
// One write port (fill) and one combinational read port (lookup).
// invalidate-all clears every valid bit and wins over a write.
// Assumes NUM_SETS >= 2 and NUM_WAYS >= 2. Tags are not reset; valid gates them.
module vtd_tag_store #(
    parameter int NUM_WAYS = 32,
    parameter int NUM_SETS = 8,
    parameter int TAG_W    = 24,
    localparam int WAY_W   = $clog2(NUM_WAYS),
    localparam int IDX_W   = $clog2(NUM_SETS)
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               inval_all,
    input  logic                               wr_en,
    input  logic [IDX_W-1:0]                   wr_set,
    input  logic [WAY_W-1:0]                   wr_way,
    input  logic [TAG_W-1:0]                   wr_tag,
    input  logic [IDX_W-1:0]                   rd_set,
    output logic [NUM_WAYS-1:0][TAG_W-1:0]     rd_tags,
    output logic [NUM_WAYS-1:0]                rd_valid
);

    for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
        logic [TAG_W-1:0]    tag_col [NUM_SETS];
        logic [NUM_SETS-1:0] vld_col;
        logic                sel;

        assign sel = wr_en && (wr_way == WAY_W'(w));

        // Tag column write on a fill into this way.
        always_ff @(posedge clk) begin
            if (sel) begin
                tag_col[wr_set] <= wr_tag;
            end
        end

        // Valid column: reset and invalidate-all clear, fill sets one bit.
        always_ff @(posedge clk) begin
            if (!rst_n || inval_all) begin
                vld_col <= '0;
            end else if (sel) begin
                vld_col[wr_set] <= 1'b1;
            end
        end

        assign rd_tags[w]  = tag_col[rd_set];
        assign rd_valid[w] = vld_col[rd_set];
    end

endmodule

// File: rtl/vtd_way_match.sv
// Parallel tag compare across all ways of one set.
// Reports a hit only if exactly one valid way matches, and encodes that way in binary.
// Purely combinational.
module vtd_way_match #(
    parameter int NUM_WAYS = 32,
    parameter int TAG_W    = 24,
    localparam int WAY_W   = $clog2(NUM_WAYS)
) (
    input  logic [NUM_WAYS-1:0][TAG_W-1:0] tags,
    input  logic [NUM_WAYS-1:0]            valid,
    input  logic [TAG_W-1:0]               cmp_tag,
    output logic                           hit,
    output logic [WAY_W-1:0]               hit_way
);

    logic [NUM_WAYS-1:0] match;
    logic                any_m;
    logic                multi_m;

    for (genvar w = 0; w < NUM_WAYS; w++) begin : g_cmp
        assign match[w] = valid[w] && (tags[w] == cmp_tag);
    end

    // Detect zero, one or several matches.
    always_comb begin
        any_m   = |match;
        multi_m = |(match & (match - NUM_WAYS'(1)));
        hit     = any_m && !multi_m;
    end

    // Binary encode of the match vector (only meaningful when hit).
    always_comb begin
        hit_way = '0;
        for (int w = 0; w < NUM_WAYS; w++) begin
            if (match[w]) begin
                hit_way = hit_way | WAY_W'(w);
            end
        end
    end

endmodule

// File: rtl/vtd_victim_regs.sv
// One victim way register per set, with three read ports:
// lookup set, fill set and register port.
// A register write takes priority over the post-fill advance to the same set.
// The advance wraps modulo NUM_WAYS.
module vtd_victim_regs
    import vtd_pkg::*;
#(
    parameter int NUM_WAYS = 32,
    parameter int NUM_SETS = 8,
    localparam int WAY_W   = $clog2(NUM_WAYS),
    localparam int IDX_W   = $clog2(NUM_SETS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv_en,
    input  logic [IDX_W-1:0] adv_set,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_set,
    input  logic [WAY_W-1:0] wr_data,
    input  logic [IDX_W-1:0] lk_set,
    output logic [WAY_W-1:0] lk_victim,
    output logic [WAY_W-1:0] adv_victim,
    input  logic [IDX_W-1:0] rd_set,
    output logic [REG_W-1:0] rd_data
);

    logic [NUM_SETS-1:0][WAY_W-1:0] vic;

    for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
        logic [WAY_W-1:0] v_q;
        logic [WAY_W-1:0] v_next;

        // Next victim after a fill: increment with wrap at NUM_WAYS.
        always_comb begin
            v_next = (v_q == WAY_W'(NUM_WAYS - 1)) ? '0 : v_q + WAY_W'(1);
        end

        // Victim register: software write beats advance.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                v_q <= '0;
            end else if (wr_en && (wr_set == IDX_W'(s))) begin
                v_q <= wr_data;
            end else if (adv_en && (adv_set == IDX_W'(s))) begin
                v_q <= v_next;
            end
        end

        assign vic[s] = v_q;
    end

    assign lk_victim  = vic[lk_set];
    assign adv_victim = vic[adv_set];
    assign rd_data    = {{(REG_W - WAY_W){1'b0}}, vic[rd_set]};

endmodule

// File: rtl/victim_tag_dir.sv
// Tag directory with per-set software-programmable victim selection.
// Address split: [OFFSET_W-1:0] offset, next IDX_W bits set, rest tag.
// Lookups respond one cycle later. Fills install into the set's victim way and
// advance that victim register. Inhibited lookups bypass and never request a fill.
// Assumes power-of-two NUM_WAYS and NUM_SETS, both >= 2.
module victim_tag_dir
    import vtd_pkg::*;
#(
    parameter int NUM_WAYS = 32,
    parameter int NUM_SETS = 8,
    parameter int ADDR_W   = 32,
    localparam int WAY_W   = $clog2(NUM_WAYS),
    localparam int IDX_W   = $clog2(NUM_SETS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic [ADDR_W-1:0] lk_addr,
    input  logic              lk_inhibit,
    input  logic              fill_en,
    input  logic [ADDR_W-1:0] fill_addr,
    input  logic              inval_all,
    input  logic              reg_we,
    input  logic [IDX_W-1:0]  reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [WAY_W-1:0]  rsp_way,
    output logic              rsp_fill,
    output logic              rsp_bypass,
    output logic [WAY_W-1:0]  rsp_victim
);

    localparam int TAG_W = ADDR_W - OFFSET_W - IDX_W;

    logic [IDX_W-1:0]              lk_set;
    logic [TAG_W-1:0]              lk_tag;
    logic [IDX_W-1:0]              fl_set;
    logic [TAG_W-1:0]              fl_tag;
    logic                          fl_go;
    logic [NUM_WAYS-1:0][TAG_W-1:0] set_tags;
    logic [NUM_WAYS-1:0]           set_valid;
    logic                          hit;
    logic [WAY_W-1:0]              hit_way;
    logic [WAY_W-1:0]              lk_victim;
    logic [WAY_W-1:0]              fl_victim;
    logic                          unused_low_bits;

    // Address field extraction for the lookup and fill paths.
    assign lk_set = lk_addr[OFFSET_W +: IDX_W];
    assign lk_tag = lk_addr[ADDR_W-1 -: TAG_W];
    assign fl_set = fill_addr[OFFSET_W +: IDX_W];
    assign fl_tag = fill_addr[ADDR_W-1 -: TAG_W];
    assign unused_low_bits = ^{lk_addr[OFFSET_W-1:0], fill_addr[OFFSET_W-1:0],
                               reg_wdata[REG_W-1:WAY_W]};

    // A fill coinciding with invalidate-all is dropped.
    assign fl_go = fill_en && !inval_all;

    vtd_tag_store #(
        .NUM_WAYS (NUM_WAYS),
        .NUM_SETS (NUM_SETS),
        .TAG_W    (TAG_W)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .inval_all (inval_all),
        .wr_en     (fl_go),
        .wr_set    (fl_set),
        .wr_way    (fl_victim),
        .wr_tag    (fl_tag),
        .rd_set    (lk_set),
        .rd_tags   (set_tags),
        .rd_valid  (set_valid)
    );

    vtd_way_match #(
        .NUM_WAYS (NUM_WAYS),
        .TAG_W    (TAG_W)
    ) u_match (
        .tags    (set_tags),
        .valid   (set_valid),
        .cmp_tag (lk_tag),
        .hit     (hit),
        .hit_way (hit_way)
    );

    vtd_victim_regs #(
        .NUM_WAYS (NUM_WAYS),
        .NUM_SETS (NUM_SETS)
    ) u_victim (
        .clk        (clk),
        .rst_n      (rst_n),
        .adv_en     (fl_go),
        .adv_set    (fl_set),
        .wr_en      (reg_we),
        .wr_set     (reg_addr),
        .wr_data    (reg_wdata[WAY_W-1:0]),
        .lk_set     (lk_set),
        .lk_victim  (lk_victim),
        .adv_victim (fl_victim),
        .rd_set     (reg_addr),
        .rd_data    (reg_rdata)
    );

    // Response register: one-cycle lookup result, zero when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid  <= 1'b0;
            rsp_hit    <= 1'b0;
            rsp_way    <= '0;
            rsp_fill   <= 1'b0;
            rsp_bypass <= 1'b0;
            rsp_victim <= '0;
        end else begin
            rsp_valid  <= lk_valid;
            rsp_hit    <= lk_valid && hit;
            rsp_way    <= (lk_valid && hit) ? hit_way : '0;
            rsp_fill   <= lk_valid && !hit && !lk_inhibit;
            rsp_bypass <= lk_valid && lk_inhibit;
            rsp_victim <= lk_valid ? lk_victim : '0;
        end
    end

endmodule

// File: rtl/victim_tag_dir_chk.sv
// Property checker for victim_tag_dir, attached by bind.
// Observes ports only.
module victim_tag_dir_chk #(
    parameter int NUM_WAYS = 32,
    parameter int NUM_SETS = 8,
    localparam int WAY_W   = $clog2(NUM_WAYS),
    localparam int IDX_W   = $clog2(NUM_SETS)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             lk_valid,
    input logic             lk_inhibit,
    input logic             inval_all,
    input logic             reg_we,
    input logic [IDX_W-1:0] reg_addr,
    input logic [31:0]      reg_wdata,
    input logic [31:0]      reg_rdata,
    input logic             rsp_valid,
    input logic             rsp_hit,
    input logic             rsp_fill,
    input logic             rsp_bypass
);

    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> (!rsp_valid && !rsp_hit && !rsp_fill && !rsp_bypass));

    a_r2_resp_next: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> rsp_valid);

    a_r5_hit_no_fill: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> !rsp_fill);

    a_r6_inhibit_bypass: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && lk_inhibit) |=> (rsp_bypass && !rsp_fill));

    a_r10_inval_miss: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && $past(inval_all)) |=> !rsp_hit);

    a_r9_write_masked: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(reg_we) && (reg_addr == $past(reg_addr)))
        |-> (reg_rdata == {{(32 - WAY_W){1'b0}}, $past(reg_wdata[WAY_W-1:0])}));

    a_r9_zero_ext: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[31:WAY_W] == '0);

endmodule

bind victim_tag_dir victim_tag_dir_chk #(
    .NUM_WAYS (NUM_WAYS),
    .NUM_SETS (NUM_SETS)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .lk_valid   (lk_valid),
    .lk_inhibit (lk_inhibit),
    .inval_all  (inval_all),
    .reg_we     (reg_we),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .rsp_valid  (rsp_valid),
    .rsp_hit    (rsp_hit),
    .rsp_fill   (rsp_fill),
    .rsp_bypass (rsp_bypass)
);

// File: tb/victim_tag_dir_tb.sv
`timescale 1ns/1ps
// Self-checking bench: directed corners plus seeded random traffic against a bench model.
module victim_tag_dir_tb;
    localparam int W  = 8;
    localparam int S  = 4;
    localparam int IW = 2;
    localparam int WW = 3;
    localparam int TW = 32 - 5 - IW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          lk_valid = 1'b0;
    logic [31:0]   lk_addr = '0;
    logic          lk_inhibit = 1'b0;
    logic          fill_en = 1'b0;
    logic [31:0]   fill_addr = '0;
    logic          inval_all = 1'b0;
    logic          reg_we = 1'b0;
    logic [IW-1:0] reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic          rsp_valid, rsp_hit, rsp_fill, rsp_bypass;
    logic [WW-1:0] rsp_way, rsp_victim;

    int n_chk = 0;
    int n_fail = 0;

    logic [TW-1:0] mtag [S][W];
    bit            mval [S][W];
    int            mvic [S];

    always #2.5 clk = ~clk;

    victim_tag_dir #(.NUM_WAYS(W), .NUM_SETS(S), .ADDR_W(32)) u_dut (
        .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_addr(lk_addr),
        .lk_inhibit(lk_inhibit), .fill_en(fill_en), .fill_addr(fill_addr),
        .inval_all(inval_all), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rsp_valid(rsp_valid),
        .rsp_hit(rsp_hit), .rsp_way(rsp_way), .rsp_fill(rsp_fill),
        .rsp_bypass(rsp_bypass), .rsp_victim(rsp_victim));

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input int tag, input int set, input int off);
        return {TW'(tag), IW'(set), 5'(off)};
    endfunction

    // Model lookup: hit only on exactly one valid match.
    function automatic void model_lu(input logic [31:0] a, output bit h, output int way);
        int set = int'(a[6:5]);
        int cnt = 0;
        way = 0;
        for (int w = 0; w < W; w++) begin
            if (mval[set][w] && mtag[set][w] == a[31:7]) begin
                cnt++;
                way = w;
            end
        end
        h = (cnt == 1);
    endfunction

    task automatic lookup(input logic [31:0] a, input bit inh, input string req, output bit h);
        int ew;
        int set = int'(a[6:5]);
        @(negedge clk);
        lk_valid = 1'b1; lk_addr = a; lk_inhibit = inh;
        model_lu(a, h, ew);
        @(negedge clk);
        lk_valid = 1'b0; lk_inhibit = 1'b0;
        chk(rsp_valid == 1'b1, req, "rsp_valid", rsp_valid, 1);
        chk(rsp_hit == h, req, "rsp_hit", rsp_hit, h);
        if (h) chk(rsp_way == WW'(ew), req, "rsp_way", rsp_way, ew);
        chk(rsp_fill == (!h && !inh), req, "rsp_fill", rsp_fill, !h && !inh);
        chk(rsp_bypass == inh, req, "rsp_bypass", rsp_bypass, inh);
        chk(rsp_victim == WW'(mvic[set]), req, "rsp_victim", rsp_victim, mvic[set]);
    endtask

    task automatic do_fill(input logic [31:0] a);
        int set = int'(a[6:5]);
        @(negedge clk);
        fill_en = 1'b1; fill_addr = a;
        @(negedge clk);
        fill_en = 1'b0;
        mtag[set][mvic[set]] = a[31:7];
        mval[set][mvic[set]] = 1'b1;
        mvic[set] = (mvic[set] + 1) % W;
    endtask

    task automatic reg_wr(input int set, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = IW'(set); reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
        mvic[set] = int'(d[WW-1:0]);
    endtask

    task automatic reg_chk(input int set, input string req);
        @(negedge clk);
        reg_addr = IW'(set);
        #1;
        chk(reg_rdata == 32'(mvic[set]), req, "victim readback", reg_rdata, mvic[set]);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        bit h;
        logic [31:0] a, b, c;
        void'($urandom(32'd1357));
        for (int s = 0; s < S; s++) begin
            mvic[s] = 0;
            for (int w = 0; w < W; w++) begin mval[s][w] = 1'b0; mtag[s][w] = '0; end
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state
        chk(!rsp_valid && !rsp_hit && !rsp_fill && !rsp_bypass, "R11", "rsp after reset",
            {rsp_valid, rsp_hit, rsp_fill, rsp_bypass}, 0);
        for (int s = 0; s < S; s++) reg_chk(s, "R11");

        // R5: cold miss requests a fill with victim 0
        a = mk(32'h1A5, 2, 0);
        lookup(a, 1'b0, "R5", h);
        // R2: idle cycle after a lookup
        @(negedge clk);
        chk(!rsp_valid && !rsp_fill, "R2", "idle response", {rsp_valid, rsp_fill}, 0);
        // R7/R1/R3: fill then hit at another offset
        do_fill(a);
        lookup(mk(32'h1A5, 2, 31), 1'b0, "R1", h);
        chk(h, "R3", "model hit expected", h, 1);
        reg_chk(2, "R7");
        // R4: duplicate tag in two ways -> miss
        do_fill(a);
        lookup(a, 1'b0, "R4", h);
        chk(!h, "R4", "duplicate is miss", h, 0);
        // R8/R7: steer victim back to way 0, evict with another tag
        reg_wr(2, 32'd0);
        b = mk(32'h2B7, 2, 4);
        do_fill(b);
        lookup(a, 1'b0, "R7", h);
        lookup(b, 1'b0, "R7", h);
        // R9: masked write and zero extension
        reg_wr(1, 32'hFFFF_FFF5);
        reg_chk(1, "R9");
        reg_wr(1, 32'd0);
        // R8: fill and register write to the same set in the same cycle
        c = mk(32'h0C3, 3, 8);
        @(negedge clk);
        fill_en = 1'b1; fill_addr = c; reg_we = 1'b1; reg_addr = 2'd3; reg_wdata = 32'd6;
        @(negedge clk);
        fill_en = 1'b0; reg_we = 1'b0;
        mtag[3][mvic[3]] = c[31:7]; mval[3][mvic[3]] = 1'b1; mvic[3] = 6;
        lookup(c, 1'b0, "R8", h);
        reg_chk(3, "R8");
        // R6: inhibited miss and inhibited hit
        lookup(mk(32'h3FF, 0, 0), 1'b1, "R6", h);
        lookup(c, 1'b1, "R6", h);
        // R7: victim wrap
        reg_wr(1, 32'd7);
        do_fill(mk(32'h077, 1, 0));
        reg_chk(1, "R7");
        lookup(mk(32'h077, 1, 0), 1'b0, "R7", h);

        // Random traffic
        for (int i = 0; i < 600; i++) begin
            int op = int'($urandom_range(99));
            int tg = int'($urandom_range(11)) + 32'h40;
            int st = int'($urandom_range(S - 1));
            logic [31:0] ra = mk(tg, st, int'($urandom_range(31)));
            if (op < 75) begin
                bit inh = ($urandom_range(7) == 0);
                lookup(ra, inh, "R3", h);
                if (!h && !inh) do_fill(ra);
            end else if (op < 88) begin
                reg_wr(st, $urandom());
                reg_chk(st, "R9");
            end else if (op < 92) begin
                @(negedge clk); inval_all = 1'b1;
                @(negedge clk); inval_all = 1'b0;
                for (int s = 0; s < S; s++) for (int w = 0; w < W; w++) mval[s][w] = 1'b0;
                reg_chk(st, "R10");
            end else begin
                do_fill(ra);
            end
        end

        // R10: invalidate-all together with a fill
        @(negedge clk);
        inval_all = 1'b1; fill_en = 1'b1; fill_addr = mk(32'h5D, 0, 0);
        @(negedge clk);
        inval_all = 1'b0; fill_en = 1'b0;
        for (int s = 0; s < S; s++) for (int w = 0; w < W; w++) mval[s][w] = 1'b0;
        lookup(mk(32'h5D, 0, 0), 1'b0, "R10", h);
        lookup(c, 1'b0, "R10", h);
        for (int s = 0; s < S; s++) reg_chk(s, "R10");

        summary();
        $finish;
    end
endmodule